// File: doc/BRIEF.md
# Latching Inverting Bus Transceiver

This block sits between a local parallel port (the A side) and a shared, active-low, wired-OR backplane bus (the B side). Data going from A to B is inverted. On the way out it passes through a storage latch. A mode select and a latch enable decide whether that latch is bypassed, transparent, edge-captured or holding. The stored word can also be driven back onto the A side, so the local agent can read what it placed on the bus. In the other direction, the B bus can be steered onto the A side in inverted form. An idle-arbitration strobe copies the current B bus level into the same latch. A per-bit monitor output then shows the latch content.

Open-collector lines are modelled as per-bit pull-down enables. A line whose enable is 0 is released and reads high. The latch and the edge detectors run on a system clock. The latch enable and the arbitration strobe are sampled into registers, and their edges are found by comparing each input against its registered copy.

Top module: `bxcvr_latch`

## Requirements
- R1: On synchronous reset the latch holds all ones. After reset the monitor pulls no line (`mon_pull` = 0), and with the latch selected onto an enabled B side, every `b_pull` bit is 1.
- R2: B drives only while `b_en_hi`=1 and `b_en_lo`=0. In every other case all `b_pull` bits are 0, which means released and read as high.
- R3: Bypass. With `lat_sel`=1 and B enabled, `b_pull` equals `a_in` in the same cycle. An A bit of 1 pulls its B line low, and an A bit of 0 leaves it released.
- R4: Transparent. With `lat_sel`=0 and `lat_en`=0, `b_pull` equals `a_in` combinationally, and the latch follows `a_in` on every clock.
- R5: A rising `lat_en`, seen at the first clock edge where `lat_en`=1 after a cycle with `lat_en`=0 while `lat_sel`=0, captures `a_in`. After that, changes on `a_in` have no effect on `b_pull`.
- R6: Hold. With `lat_sel`=0, `lat_en`=1 and `a_oe`=0, the latch keeps its value, `a_drive`=0, and `b_pull` shows the stored word.
- R7: Latched-and-read. With `lat_sel`=0, `lat_en`=1 and `a_oe`=1, `a_drive`=1 and `a_out` equals the stored word.
- R8: B-to-A. With B disabled, `lat_sel`=1, `a_oe`=1 and `arb_req_n`=1, `a_drive`=1 and `a_out` = ~`b_in`. In `b_in`, bit 1 means the line reads high.
- R9: Arbitration snapshot. A falling `arb_req_n` (1 at one clock edge, 0 at the next) while B is disabled and `lat_sel`=`lat_en`=1 loads `b_in` into the latch at that second edge. While `arb_req_n`=0, A is released.
- R10: Monitor. `mon_pull` bit = 1 exactly where the stored bit is 0, so a stored 1 leaves the line released.
- R11: While `a_oe`=0, `a_drive`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | Level on the A side pins |
| b_in | input | WIDTH | Level on the B bus (1 = line high) |
| b_en_hi | input | 1 | B enable, active high |
| b_en_lo | input | 1 | B enable, active low |
| lat_sel | input | 1 | 1 = bypass latch, 0 = use latch |
| a_oe | input | 1 | A side output enable |
| lat_en | input | 1 | Latch enable (0 = transparent, rising = capture) |
| arb_req_n | input | 1 | Idle-arbitration strobe, active on falling edge |
| b_pull | output | WIDTH | Per-bit B pull-down enable |
| a_out | output | WIDTH | A side drive data |
| a_drive | output | 1 | A side drive enable |
| mon_pull | output | WIDTH | Per-bit arbitration monitor pull-down |

## Verification
The outputs `b_pull`, `a_out` and `a_drive` are combinational in the inputs and the latch. The bench applies inputs on the falling clock edge and checks these outputs 1 ns later, before any rising edge. Capture, transparency tracking and the arbitration snapshot take effect at the next rising edge. Those results, and `mon_pull`, are checked 1 ns after that edge. Because the edge detectors compare each input against a registered copy, each strobe is held for one full clock before it counts as an edge, and the stimulus is ordered to match.

// File: rtl/bxcvr_pkg.sv
package bxcvr_pkg;

    typedef enum logic [1:0] {
        SRC_A_DIRECT = 2'd0,
        SRC_LATCH    = 2'd1
    } bsrc_e;

    typedef struct packed {
        logic  b_on;       // B side pulls allowed
        bsrc_e b_src;      // word that feeds B
        logic  transp;     // latch follows A each clock
        logic  cap_ok;     // latch edge capture permitted
        logic  arb_ok;     // arbitration snapshot permitted
        logic  a_rd_latch; // A shows stored word
        logic  a_rd_bus;   // A shows inverted B bus
    } ctl_t;

    function automatic logic b_enabled(input logic hi, input logic lo);
        return hi & ~lo;
    endfunction

    function automatic ctl_t decode(input logic hi, input logic lo,
                                    input logic sel, input logic le,
                                    input logic arb_n);
        ctl_t c;
        c.b_on       = b_enabled(hi, lo);
        c.b_src      = (sel | ~le) ? SRC_A_DIRECT : SRC_LATCH;
        c.transp     = ~sel & ~le;
        c.cap_ok     = ~sel;
        c.arb_ok     = ~c.b_on & sel & le;
        c.a_rd_latch = ~sel & le;
        c.a_rd_bus   = ~c.b_on & sel & arb_n;
        return c;
    endfunction

endpackage

// File: rtl/bxcvr_edge.sv
module bxcvr_edge (
    input  logic clk,
    input  logic rst,
    input  logic lat_en,
    input  logic arb_req_n,
    output logic le_rise,
    output logic arb_fall
);
    logic le_q;
    logic arb_q;

    // Reset values chosen so no false edge appears right after reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            le_q  <= 1'b1;
            arb_q <= 1'b0;
        end else begin
            le_q  <= lat_en;
            arb_q <= arb_req_n;
        end
    end

    assign le_rise  = lat_en & ~le_q;
    assign arb_fall = ~arb_req_n & arb_q;

    a_r5_one_rise: assert property (@(posedge clk) disable iff (rst)
        le_rise |=> !le_rise);
    a_r9_one_fall: assert property (@(posedge clk) disable iff (rst)
        arb_fall |=> !arb_fall);
endmodule

// File: rtl/bxcvr_store.sv
module bxcvr_store #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             transp,
    input  logic             cap_ok,
    input  logic             le_rise,
    input  logic             arb_ok,
    input  logic             arb_fall,
    output logic [WIDTH-1:0] latch_q
);
    logic do_arb;
    logic do_a;

    assign do_arb = arb_ok & arb_fall;
    assign do_a   = transp | (cap_ok & le_rise);

    always_ff @(posedge clk) begin
        if (rst)         latch_q <= '1;
        else if (do_arb) latch_q <= b_in;
        else if (do_a)   latch_q <= a_in;
    end

    a_r1_reset_ones: assert property (@(posedge clk)
        rst |=> latch_q == '1);
    a_r9_snapshot: assert property (@(posedge clk) disable iff (rst)
        (arb_ok && arb_fall) |=> latch_q == $past(b_in));
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!transp && !le_rise && !arb_fall) |=> $stable(latch_q));
endmodule

// File: rtl/bxcvr_drive.sv
module bxcvr_drive
    import bxcvr_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input  ctl_t             ctl,
    input  logic             a_oe,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] b_pull,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drive,
    output logic [WIDTH-1:0] mon_pull
);
    logic [WIDTH-1:0] src;

    always_comb begin
        src = (ctl.b_src == SRC_LATCH) ? latch_q : a_in;
        // A bit of 1 pulls the line low: the bus carries inverted data.
        b_pull = ctl.b_on ? src : '0;
    end

    always_comb begin
        a_drive = a_oe & (ctl.a_rd_latch | ctl.a_rd_bus);
        if (ctl.a_rd_latch) a_out = latch_q;
        else                a_out = ~b_in;
    end

    // A stored 0 pulls the monitor line low.
    for (genvar i = 0; i < WIDTH; i++) begin : g_mon
        assign mon_pull[i] = ~latch_q[i];
    end

    always_comb begin
        if (!a_oe) a_r11_a_released: assert (!a_drive);
    end
endmodule

// File: rtl/bxcvr_latch.sv
module bxcvr_latch
    import bxcvr_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             b_en_hi,
    input  logic             b_en_lo,
    input  logic             lat_sel,
    input  logic             a_oe,
    input  logic             lat_en,
    input  logic             arb_req_n,
    output logic [WIDTH-1:0] b_pull,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drive,
    output logic [WIDTH-1:0] mon_pull
);
    ctl_t             ctl;
    logic             le_rise;
    logic             arb_fall;
    logic [WIDTH-1:0] latch_q;

    assign ctl = decode(b_en_hi, b_en_lo, lat_sel, lat_en, arb_req_n);

    bxcvr_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .lat_en    (lat_en),
        .arb_req_n (arb_req_n),
        .le_rise   (le_rise),
        .arb_fall  (arb_fall)
    );

    bxcvr_store #(.WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .a_in     (a_in),
        .b_in     (b_in),
        .transp   (ctl.transp),
        .cap_ok   (ctl.cap_ok),
        .le_rise  (le_rise),
        .arb_ok   (ctl.arb_ok),
        .arb_fall (arb_fall),
        .latch_q  (latch_q)
    );

    bxcvr_drive #(.WIDTH(WIDTH)) u_drive (
        .ctl      (ctl),
        .a_oe     (a_oe),
        .a_in     (a_in),
        .b_in     (b_in),
        .latch_q  (latch_q),
        .b_pull   (b_pull),
        .a_out    (a_out),
        .a_drive  (a_drive),
        .mon_pull (mon_pull)
    );

    a_r2_b_released: assert property (@(posedge clk) disable iff (rst)
        !(b_en_hi && !b_en_lo) |-> b_pull == '0);
    a_r10_mon_matches_b: assert property (@(posedge clk) disable iff (rst)
        (!lat_sel && lat_en && b_en_hi && !b_en_lo) |-> b_pull == ~mon_pull);
    a_r7_read_back: assert property (@(posedge clk) disable iff (rst)
        (!lat_sel && lat_en && a_oe) |-> (a_drive && a_out == ~mon_pull));
endmodule

// File: tb/sim_bxcvr_latch.sv
`timescale 1ns/1ps
module sim_bxcvr_latch;
    localparam int W = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '1;
    logic b_en_hi = 1'b0, b_en_lo = 1'b1, lat_sel = 1'b0, a_oe = 1'b0;
    logic lat_en = 1'b1, arb_req_n = 1'b1;
    logic [W-1:0] b_pull, a_out, mon_pull;
    logic a_drive;

    int vecs = 0;
    int errs = 0;

    always #2.5 clk = ~clk;

    bxcvr_latch #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .b_en_hi(b_en_hi), .b_en_lo(b_en_lo), .lat_sel(lat_sel),
        .a_oe(a_oe), .lat_en(lat_en), .arb_req_n(arb_req_n),
        .b_pull(b_pull), .a_out(a_out), .a_drive(a_drive),
        .mon_pull(mon_pull)
    );

    task automatic chk(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Move to the next falling edge (input drive point).
    task automatic to_neg();
        @(negedge clk);
    endtask

    // Let one rising edge pass, then settle.
    task automatic tick();
        @(posedge clk); #1;
    endtask

    initial begin : watchdog
        #900000;
        errs++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin : main
        logic [W-1:0] cap;
        logic [W-1:0] snap;
        repeat (3) tick();
        to_neg(); rst = 1'b0;
        // R1: reset state
        b_en_hi = 1; b_en_lo = 0; lat_sel = 0; lat_en = 1; a_in = '0;
        #1;
        chk("R1 latch ones on B", b_pull, '1);
        chk("R1 monitor released", mon_pull, '0);
        chk("R11 A released", {{(W-1){1'b0}}, a_drive}, '0);

        // R2: all enable combos that disable B
        lat_sel = 1;
        for (int c = 0; c < 4; c++) begin
            to_neg();
            {b_en_hi, b_en_lo} = c[1:0];
            a_in = '1;
            #1;
            chk("R2 B gating", b_pull, (c == 2) ? '1 : '0);
        end

        // R3: bypass sweep
        b_en_hi = 1; b_en_lo = 0; lat_sel = 1; a_oe = 0;
        for (int v = 0; v < (1 << W); v++) begin
            to_neg(); a_in = v[W-1:0]; #1;
            chk("R3 bypass", b_pull, v[W-1:0]);
        end

        // R4: transparent sweep, latch follows A at each clock
        to_neg(); lat_sel = 0; lat_en = 0;
        for (int v = 0; v < (1 << W); v += 7) begin
            to_neg(); a_in = v[W-1:0]; #1;
            chk("R4 transparent B", b_pull, v[W-1:0]);
            tick();
            chk("R4 latch tracks A", mon_pull, ~v[W-1:0]);
        end

        // R5/R6/R7: capture patterns
        for (int k = 0; k < 6; k++) begin
            cap = W'((k * 97 + 5) % (1 << W));
            to_neg(); lat_en = 0; lat_sel = 0; a_oe = 0; a_in = cap;
            tick();
            to_neg(); lat_en = 1;
            tick();
            to_neg(); a_in = ~cap; #1;
            chk("R5 capture holds on B", b_pull, cap);
            tick();
            chk("R6 hold after clock", b_pull, cap);
            chk("R6 A released", {{(W-1){1'b0}}, a_drive}, '0);
            chk("R10 monitor", mon_pull, ~cap);
            to_neg(); a_oe = 1; #1;
            chk("R7 A drive on", {{(W-1){1'b0}}, a_drive}, 1);
            chk("R7 A reads latch", a_out, cap);
            to_neg(); a_oe = 0; #1;
            chk("R11 A off", {{(W-1){1'b0}}, a_drive}, '0);
        end

        // R8: B-to-A sweep
        to_neg(); b_en_hi = 0; lat_sel = 1; a_oe = 1; arb_req_n = 1;
        for (int v = 0; v < (1 << W); v++) begin
            to_neg(); b_in = v[W-1:0]; #1;
            chk("R8 B-to-A data", a_out, ~v[W-1:0]);
            chk("R8 B-to-A enable", {{(W-1){1'b0}}, a_drive}, 1);
            chk("R2 B released", b_pull, '0);
        end

        // R9: arbitration snapshots
        for (int k = 0; k < 5; k++) begin
            snap = W'((k * 149 + 3) % (1 << W));
            to_neg(); b_en_hi = 0; b_en_lo = 1; lat_sel = 1; lat_en = 1;
            a_oe = 1; arb_req_n = 1; b_in = snap;
            tick();
            to_neg(); arb_req_n = 0; #1;
            chk("R9 A released", {{(W-1){1'b0}}, a_drive}, '0);
            tick();
            chk("R9 R10 snapshot on monitor", mon_pull, ~snap);
            to_neg(); b_in = ~snap; arb_req_n = 1;
            b_en_hi = 1; b_en_lo = 0; lat_sel = 0; a_oe = 0; #1;
            chk("R9 snapshot onto B", b_pull, snap);
        end

        // R1 again: reset mid-run restores ones
        to_neg(); rst = 1; tick();
        to_neg(); rst = 0; #1;
        chk("R1 reset restores ones", b_pull, '1);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule